// File: doc/BRIEF.md
# Packed Decimal Byte Adjust Unit

This block repairs the 8-bit result of an ordinary binary addition or subtraction of two packed decimal bytes, so that the result is again two valid decimal digits. A binary ALU upstream computes the raw byte together with its carry (or borrow) and its nibble carry (the carry or borrow out of bit 3). The unit takes those three values and an operation select. It then adds or removes the corrections of 0x06 and 0x60 that decimal arithmetic needs, and it returns the adjusted byte with updated carry, nibble-carry and zero flags.

Both correction decisions are made from the incoming byte and flags as they arrive. The high-digit decision does not wait for the low correction, so the two decisions are independent and the whole correction is one add or one subtract of a combined constant. A parameter selects whether the result is registered. With the register, the unit has one cycle of latency and accepts a new byte on every cycle. Without it, the result follows the input in the same cycle. A valid strobe travels with the data in both cases.

Top module: `bcd_byte_adjust`

## Requirements
- R1: With isSub=0 (add), when the raw byte's bits [3:0] exceed 9 or auxIn=1, 0x06 is added to the byte, and auxOut is 1 exactly when this low correction applies.
- R2: With isSub=0, when the raw byte exceeds 0x99 or carryIn=1, 0x60 is added to the byte (modulo 256) and carryOut is 1. Otherwise carryOut is 0.
- R3: With isSub=1 (subtract), the same two tests remove 0x06 and 0x60 instead, modulo 256, and auxOut follows the low test. carryOut (borrow) is 1 when the high test holds, or when the low correction applies to a byte below 0x06.
- R4: When the raw byte and flags come from a binary add or subtract of two valid packed decimal bytes A and B, adjByte is the packed decimal form of (A+B) mod 100 or (A-B) mod 100. carryOut is 1 exactly when A+B>99 or A<B.
- R5: When bits [3:0] are at most 9, bits [7:4] are at most 9, and auxIn=carryIn=0, adjByte equals the raw byte and carryOut=auxOut=0, for either operation.
- R6: zeroOut is 1 exactly when adjByte is 0x00.
- R7: With PIPE_STAGE=1, each accepted input (inValid=1) appears at the outputs with outValid=1 one clock later, and a new input is accepted on every cycle. With PIPE_STAGE=0, the outputs follow the inputs in the same cycle.
- R8: While rstN is low, and after it until the first accepted input, outValid is 0 and adjByte is 0x00 (registered variant).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| inValid | input | 1 | Input byte and flags are valid this cycle |
| rawByte | input | 8 | Byte produced by the binary add or subtract |
| carryIn | input | 1 | Carry (add) or borrow (subtract) out of bit 7 |
| auxIn | input | 1 | Carry or borrow out of bit 3 |
| isSub | input | 1 | 0 selects add adjustment, 1 selects subtract adjustment |
| outValid | output | 1 | Adjusted result is valid |
| adjByte | output | 8 | Adjusted packed decimal byte |
| carryOut | output | 1 | Decimal carry or borrow |
| auxOut | output | 1 | Low correction was applied |
| zeroOut | output | 1 | adjByte is 0x00 |

## Verification
Some properties are checked on every cycle against a delayed copy of the inputs. These are the valid strobe timing, the forcing of the outgoing carry by an incoming carry, the nibble-carry output raised by a low digit above 9, the unchanged pass-through of bytes that need no correction, and the zero flag. The arithmetic itself is shown only by the bench. It covers the exact corrected values for add and subtract, the decimal wrap at 100, borrow generation, and the behaviour on raw bytes above 0x99 or below 0x06. It compares each adjusted byte against decimal sums and differences worked out independently, plus directed raw bytes at those boundaries.

// File: rtl/bcd_adj_pkg.sv
package bcd_adj_pkg;
  localparam int DIGIT_W = 4;
  localparam int BYTE_W  = 2 * DIGIT_W;
  localparam logic [DIGIT_W-1:0] MAX_DIGIT = 4'd9;
  localparam logic [DIGIT_W-1:0] FIX_DIGIT = 4'd6;

  typedef struct packed {
    logic lowFix;     // apply 6 to the low digit
    logic highFix;    // apply 6 to the high digit
    logic lowBorrow;  // subtract-only borrow from the low correction
  } fixStrobeT;
endpackage

// File: rtl/dec_adj_ctrl.sv
module dec_adj_ctrl
  import bcd_adj_pkg::*;
(
  input  logic [BYTE_W-1:0] rawByte,
  input  logic              carryIn,
  input  logic              auxIn,
  input  logic              isSub,
  output fixStrobeT         strobe
);
  logic [DIGIT_W-1:0] lowDigit;
  logic               byteOverLimit;
  logic               byteBelowFix;

  assign lowDigit      = rawByte[DIGIT_W-1:0];
  assign byteOverLimit = rawByte > {MAX_DIGIT, MAX_DIGIT};
  assign byteBelowFix  = rawByte < BYTE_W'(FIX_DIGIT);

  always_comb begin
    strobe.lowFix    = (lowDigit > MAX_DIGIT) || auxIn;
    // high decision is taken on the byte as it arrived
    strobe.highFix   = byteOverLimit || carryIn;
    strobe.lowBorrow = isSub && strobe.lowFix && byteBelowFix;
  end
endmodule

// File: rtl/dec_adj_datapath.sv
module dec_adj_datapath
  import bcd_adj_pkg::*;
#(
  parameter bit PIPE_STAGE = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [BYTE_W-1:0] rawByte,
  input  logic              isSub,
  input  fixStrobeT         strobe,
  output logic              outValid,
  output logic [BYTE_W-1:0] adjByte,
  output logic              carryOut,
  output logic              auxOut,
  output logic              zeroOut
);
  logic [BYTE_W-1:0] corrValue;
  logic [BYTE_W-1:0] nextByte;
  logic              nextCarry;
  logic              nextAux;
  logic              nextZero;

  always_comb begin
    corrValue = {(strobe.highFix ? FIX_DIGIT : '0), (strobe.lowFix ? FIX_DIGIT : '0)};
    nextByte  = isSub ? (rawByte - corrValue) : (rawByte + corrValue);
    nextCarry = strobe.highFix || strobe.lowBorrow;
    nextAux   = strobe.lowFix;
    nextZero  = (nextByte == '0);
  end

  generate
    if (PIPE_STAGE) begin : gRegistered
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          outValid <= 1'b0;
          adjByte  <= '0;
          carryOut <= 1'b0;
          auxOut   <= 1'b0;
          zeroOut  <= 1'b0;
        end else begin
          outValid <= inValid;
          if (inValid) begin
            adjByte  <= nextByte;
            carryOut <= nextCarry;
            auxOut   <= nextAux;
            zeroOut  <= nextZero;
          end
        end
      end
    end else begin : gDirect
      assign outValid = inValid;
      assign adjByte  = nextByte;
      assign carryOut = nextCarry;
      assign auxOut   = nextAux;
      assign zeroOut  = nextZero;
    end
  endgenerate
endmodule

// File: rtl/bcd_byte_adjust.sv
module bcd_byte_adjust
  import bcd_adj_pkg::*;
#(
  parameter bit PIPE_STAGE = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [7:0] rawByte,
  input  logic       carryIn,
  input  logic       auxIn,
  input  logic       isSub,
  output logic       outValid,
  output logic [7:0] adjByte,
  output logic       carryOut,
  output logic       auxOut,
  output logic       zeroOut
);
  fixStrobeT strobe;

  dec_adj_ctrl uCtrl (
    .rawByte (rawByte),
    .carryIn (carryIn),
    .auxIn   (auxIn),
    .isSub   (isSub),
    .strobe  (strobe)
  );

  dec_adj_datapath #(.PIPE_STAGE(PIPE_STAGE)) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .rawByte  (rawByte),
    .isSub    (isSub),
    .strobe   (strobe),
    .outValid (outValid),
    .adjByte  (adjByte),
    .carryOut (carryOut),
    .auxOut   (auxOut),
    .zeroOut  (zeroOut)
  );
endmodule

// File: rtl/bcd_byte_adjust_checker.sv
module bcd_byte_adjust_checker #(
  parameter bit PIPE_STAGE = 1'b1
) (
  input logic       clk,
  input logic       rstN,
  input logic       inValid,
  input logic [7:0] rawByte,
  input logic       carryIn,
  input logic       auxIn,
  input logic       outValid,
  input logic [7:0] adjByte,
  input logic       carryOut,
  input logic       auxOut,
  input logic       zeroOut
);
  logic       seenValid;
  logic [7:0] seenRaw;
  logic       seenCarry;
  logic       seenAux;

  generate
    if (PIPE_STAGE) begin : gDelay
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          seenValid <= 1'b0;
          seenRaw   <= '0;
          seenCarry <= 1'b0;
          seenAux   <= 1'b0;
        end else begin
          seenValid <= inValid;
          seenRaw   <= rawByte;
          seenCarry <= carryIn;
          seenAux   <= auxIn;
        end
      end
    end else begin : gSame
      assign seenValid = inValid;
      assign seenRaw   = rawByte;
      assign seenCarry = carryIn;
      assign seenAux   = auxIn;
    end
  endgenerate

  assert_valid_latency_R7: assert property (@(posedge clk) disable iff (!rstN)
    outValid == seenValid);

  assert_carry_forced_R2: assert property (@(posedge clk) disable iff (!rstN)
    (seenValid && seenCarry) |-> carryOut);

  assert_low_fix_flag_R1: assert property (@(posedge clk) disable iff (!rstN)
    (seenValid && (seenRaw[3:0] > 4'd9)) |-> auxOut);

  assert_pass_through_R5: assert property (@(posedge clk) disable iff (!rstN)
    (seenValid && !seenCarry && !seenAux && seenRaw[3:0] <= 4'd9 && seenRaw[7:4] <= 4'd9)
      |-> (adjByte == seenRaw && !carryOut && !auxOut));

  assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (zeroOut == (adjByte == 8'h00)));
endmodule

bind bcd_byte_adjust bcd_byte_adjust_checker #(.PIPE_STAGE(PIPE_STAGE)) uChecker (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .rawByte  (rawByte),
  .carryIn  (carryIn),
  .auxIn    (auxIn),
  .outValid (outValid),
  .adjByte  (adjByte),
  .carryOut (carryOut),
  .auxOut   (auxOut),
  .zeroOut  (zeroOut)
);

// File: tb/bcd_byte_adjust_test.sv
module bcd_byte_adjust_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 20000;

  typedef struct {
    logic [7:0] expByte;
    logic       expCarry;
    logic       expAux;
    string      tag;
  } expItemT;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [7:0] rawByte = '0;
  logic       carryIn = 1'b0;
  logic       auxIn = 1'b0;
  logic       isSub = 1'b0;
  logic       outValid;
  logic [7:0] adjByte;
  logic       carryOut;
  logic       auxOut;
  logic       zeroOut;

  int vecCount = 0;
  int failCount = 0;
  bit driveDone = 1'b0;
  expItemT expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_byte_adjust uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .rawByte(rawByte),
    .carryIn(carryIn), .auxIn(auxIn), .isSub(isSub), .outValid(outValid),
    .adjByte(adjByte), .carryOut(carryOut), .auxOut(auxOut), .zeroOut(zeroOut)
  );

  function automatic logic [7:0] toBcd(int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  task automatic sendRaw(logic [7:0] raw, logic cin, logic ain, logic sub,
                         logic [7:0] eByte, logic eCarry, logic eAux, string tag);
    expItemT it;
    @(negedge clk);
    rawByte = raw; carryIn = cin; auxIn = ain; isSub = sub; inValid = 1'b1;
    it.expByte = eByte; it.expCarry = eCarry; it.expAux = eAux; it.tag = tag;
    expQ.push_back(it);
  endtask

  // R4: binary op on two decimal bytes, expected result computed in decimal
  task automatic sendBcd(int a, int b, logic sub);
    logic [7:0] ba, bb, raw;
    logic       cin, ain, eCarry;
    int         res;
    ba = toBcd(a); bb = toBcd(b);
    if (sub) begin
      raw = ba - bb;
      cin = ba < bb;
      ain = ba[3:0] < bb[3:0];
      res = (a - b + 100) % 100;
      eCarry = a < b;
    end else begin
      raw = ba + bb;
      cin = (9'(ba) + 9'(bb)) > 9'd255;
      ain = (5'(ba[3:0]) + 5'(bb[3:0])) > 5'd15;
      res = (a + b) % 100;
      eCarry = (a + b) > 99;
    end
    sendRaw(raw, cin, ain, sub, toBcd(res), eCarry,
            (raw[3:0] > 4'd9) || ain, "R4");
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rstN && outValid) begin
      expItemT it;
      vecCount++;
      if (expQ.size() == 0) begin
        failCount++;
        $display("FAIL R7: outValid with no pending item, actual byte %h expected none", adjByte);
      end else begin
        it = expQ.pop_front();
        if (adjByte !== it.expByte || carryOut !== it.expCarry || auxOut !== it.expAux) begin
          failCount++;
          $display("FAIL %s: actual byte=%h c=%b a=%b expected byte=%h c=%b a=%b",
                   it.tag, adjByte, carryOut, auxOut, it.expByte, it.expCarry, it.expAux);
        end
        if (zeroOut !== (it.expByte == 8'h00)) begin
          failCount++;
          $display("FAIL R6: actual zero=%b expected %b", zeroOut, it.expByte == 8'h00);
        end
      end
    end
  end

  initial begin
    int cycles = 0;
    while (cycles < WATCHDOG_CYCLES && !driveDone) begin
      @(posedge clk);
      cycles++;
    end
    if (!driveDone) begin
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    vecCount++;
    if (outValid !== 1'b0 || adjByte !== 8'h00) begin
      failCount++;
      $display("FAIL R8: actual valid=%b byte=%h expected valid=0 byte=00", outValid, adjByte);
    end
    rstN = 1'b1;
    idle(2);
    vecCount++;
    if (outValid !== 1'b0 || adjByte !== 8'h00) begin
      failCount++;
      $display("FAIL R8: after reset actual valid=%b byte=%h expected 0/00", outValid, adjByte);
    end

    // R1/R2 add corrections on raw bytes
    sendRaw(8'hFF, 0, 0, 0, 8'h65, 1, 1, "R2");
    sendRaw(8'h9A, 0, 0, 0, 8'h00, 1, 1, "R2");
    sendRaw(8'h3C, 0, 0, 0, 8'h42, 0, 1, "R1");
    sendRaw(8'hA5, 0, 0, 0, 8'h05, 1, 0, "R2");
    sendRaw(8'h25, 0, 1, 0, 8'h2B, 0, 1, "R1");
    sendRaw(8'h12, 1, 0, 0, 8'h72, 1, 0, "R2");
    // R5 untouched bytes
    sendRaw(8'h47, 0, 0, 0, 8'h47, 0, 0, "R5");
    sendRaw(8'h99, 0, 0, 1, 8'h99, 0, 0, "R5");
    idle(1);
    // R3 subtract corrections
    sendRaw(8'h03, 0, 1, 1, 8'hFD, 1, 1, "R3");
    sendRaw(8'h2F, 0, 1, 1, 8'h29, 0, 1, "R3");
    sendRaw(8'hF5, 1, 0, 1, 8'h95, 1, 0, "R3");
    sendRaw(8'hAB, 0, 0, 1, 8'h45, 1, 1, "R3");
    // R6 zero
    sendRaw(8'h00, 0, 0, 1, 8'h00, 0, 0, "R6");
    idle(2);
    // R4 directed decimal cases
    sendBcd(45, 38, 0);
    sendBcd(99, 1, 0);
    sendBcd(58, 67, 0);
    sendBcd(0, 0, 0);
    sendBcd(72, 35, 1);
    sendBcd(35, 72, 1);
    sendBcd(50, 50, 1);
    sendBcd(0, 99, 1);
    // R4/R7 back-to-back sweep
    for (int a = 0; a < 100; a += 7) begin
      for (int b = 0; b < 100; b += 11) begin
        sendBcd(a, b, 0);
        sendBcd(a, b, 1);
      end
    end
    idle(4);
    if (expQ.size() != 0) begin
      failCount++;
      $display("FAIL R7: actual %0d results missing expected 0", expQ.size());
    end
    driveDone = 1'b1;
  end
endmodule